// File: doc/BRIEF.md
# ADC Sample and Conversion Timer

This block is the timing core behind a serial analog-to-digital converter. It watches a serial clock, an active-low chip select, a frame-sync line and an active-low start strobe. From these it decides when the input is sampled and when a conversion runs. All inputs are treated as levels that are synchronous to the system clock `clk`. Edges are found by comparing each input with its value one clock earlier.

A frame starts on a chip-select falling edge or a frame-sync rising edge. Sampling then counts serial-clock edges. In the short setting, conversion begins on the 16th serial-clock falling edge of the frame. In the long setting it begins on the 48th. A start-strobe falling edge that comes late enough in a frame moves the block into extended mode. In that mode the strobe alone opens and closes the sampling window. Extended mode is left only after two frame edges in a row, and the first of those two starts nothing. A conversion lasts a fixed number of conversion clocks. Each conversion clock is either an oscillator tick or a group of four serial-clock rising edges. At the end of a conversion, a fixed stub result word is loaded in place of a real analog result.

The controller has four states. IDLE waits for a trigger. SAMPLE counts serial-clock edges. EXT_SAMPLE holds while the strobe is low. CONVERT counts conversion clocks. The transitions are:
- IDLE to SAMPLE on a frame edge, when not in extended mode or when extended mode is already armed for exit.
- IDLE stays in IDLE and arms the exit on the first frame edge in extended mode.
- IDLE to EXT_SAMPLE on a strobe fall while in extended mode.
- SAMPLE to EXT_SAMPLE on a strobe fall that comes late enough.
- SAMPLE to CONVERT on the last counted serial-clock falling edge.
- EXT_SAMPLE to CONVERT on a strobe rise.
- CONVERT to IDLE on the final conversion clock.

Top module: `adc_sample_timer`

## Requirements
- R1: While reset is held and after it is released, `eoc_o`=1, `int_n_o`=1, `sampling_o`=0, `ext_mode_o`=0, `early_err_o`=0, `overrun_o`=0, `result_o`=0 and `result_valid_o`=0.
- R2: A frame edge is a `cs_n` falling edge or an `fs` rising edge. A frame edge in IDLE, outside extended mode, raises `sampling_o` one clock later. A frame edge that arrives during SAMPLE or EXT_SAMPLE is ignored.
- R3: With `long_sel`=0, the 16th `sclk` falling edge of a frame starts conversion. The 15th falling edge leaves `eoc_o` high.
- R4: With `long_sel`=1, the 48th `sclk` falling edge starts conversion. The 47th falling edge does not.
- R5: A `strobe_n` falling edge during SAMPLE, after at least 11 `sclk` rising edges in the frame, does three things: it enters EXT_SAMPLE, it sets `ext_mode_o`, and it keeps `sampling_o` high until `strobe_n` rises, which starts conversion. While in extended mode, a later strobe falling edge in IDLE starts extended sampling directly.
- R6: A strobe falling edge is ignored in two cases: when it comes before the 11th `sclk` rising edge of a frame, or when it comes in IDLE outside extended mode. Either case sets `early_err_o`, which stays at 1 until reset.
- R7: In extended mode, the first frame edge seen in IDLE starts nothing. A second frame edge, with no strobe falling edge in between, clears `ext_mode_o` and starts a normal frame. The two frame edges may be of either kind.
- R8: A conversion lasts 13 conversion clocks, and counting starts one clock after conversion begins. With `conv_src`=0, each `osc_tick` pulse is one conversion clock. With `conv_src`=1, every 4th `sclk` rising edge is one conversion clock.
- R9: `eoc_o` is low exactly while converting. In the clock where `eoc_o` returns high, `int_n_o` goes low, `result_o` holds the stub value 0xA5C, and `result_valid_o` pulses for one clock.
- R10: `int_n_o` returns high on the next frame edge, in any state.
- R11: A frame edge or a strobe falling edge during CONVERT does not shorten the conversion. Each such trigger adds one to `overrun_o`, which saturates at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock level |
| cs_n | input | 1 | Chip select, active low |
| fs | input | 1 | Frame sync |
| strobe_n | input | 1 | External start strobe, active low |
| osc_tick | input | 1 | Internal oscillator tick, one clock wide |
| long_sel | input | 1 | 1 selects the long sampling count |
| conv_src | input | 1 | 1 takes conversion clocks from the serial clock |
| eoc_o | output | 1 | End-of-conversion flag, low while converting |
| int_n_o | output | 1 | Interrupt flag, active low |
| sampling_o | output | 1 | High during any sampling window |
| ext_mode_o | output | 1 | Extended (strobe-driven) mode active |
| early_err_o | output | 1 | Sticky flag for an early or stray strobe |
| overrun_o | output | 4 | Saturating count of ignored triggers |
| result_o | output | 12 | Result word from the stub |
| result_valid_o | output | 1 | One-clock pulse when a result is loaded |

## Verification
The assertions take four things for granted about the inputs:
- Each input is synchronous to `clk`, and its level is held for at least one clock.
- `long_sel` does not change within a frame.
- `conv_src` does not change during a conversion.
- Frame edges and strobe edges do not happen in the same clock.

The stimulus keeps to these by changing inputs only on the falling edge of `clk`, by giving each serial-clock phase a full clock, and by changing the two configuration inputs only while the block is idle.

// File: rtl/adc_timer_pkg.sv
package adc_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_EXT_SAMPLE,
        ST_CONVERT
    } tmr_state_e;

    localparam int NUM_EDGE_IN = 4;
    localparam int IX_SCLK     = 0;
    localparam int IX_CS       = 1;
    localparam int IX_FS       = 2;
    localparam int IX_STRB     = 3;

endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
    parameter int              N       = 4,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] level_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) level_q[g] <= RST_VAL[g];
            else        level_q[g] <= level[g];
        end
        assign rise[g] =  level[g] & ~level_q[g];
        assign fall[g] = ~level[g] &  level_q[g];
    end

endmodule

// File: rtl/adc_conv_clk.sv
module adc_conv_clk #(
    parameter int CONV_CLKS = 13,
    parameter int SCLK_DIV  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    input  logic use_sclk,
    input  logic sclk_rise,
    input  logic osc_tick,
    output logic done
);

    localparam int CC_W = $clog2(CONV_CLKS + 1);
    localparam int DV_W = $clog2(SCLK_DIV + 1);
    localparam logic [CC_W-1:0] CC_LAST = CC_W'(CONV_CLKS - 1);
    localparam logic [DV_W-1:0] DV_LAST = DV_W'(SCLK_DIV - 1);

    logic [CC_W-1:0] cnt;
    logic [DV_W-1:0] div;
    logic            tick;

    assign tick = use_sclk ? (sclk_rise && div == DV_LAST) : osc_tick;
    assign done = run && tick && cnt == CC_LAST;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            div <= '0;
        end else if (start) begin
            cnt <= '0;
            div <= '0;
        end else if (run) begin
            if (sclk_rise) div <= (div == DV_LAST) ? '0 : div + 1'b1;
            if (tick)      cnt <= (cnt == CC_LAST) ? '0 : cnt + 1'b1;
        end
    end

    // R8: the conversion-clock count never passes its last value
    a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CC_LAST);

    // R8: the serial-clock divider wraps at its last value
    a_r8_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        div <= DV_LAST);

    // R8: a restart clears the count in the next clock
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cnt == '0);

endmodule

// File: rtl/adc_sample_timer.sv
module adc_sample_timer
    import adc_timer_pkg::*;
#(
    parameter int              SHORT_FALLS    = 16,
    parameter int              LONG_FALLS     = 48,
    parameter int              STRB_MIN_RISES = 11,
    parameter int              CONV_CLKS      = 13,
    parameter int              SCLK_DIV       = 4,
    parameter int              RES_W          = 12,
    parameter logic [RES_W-1:0] RESULT_STUB   = 12'hA5C,
    parameter int              OVR_W          = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             fs,
    input  logic             strobe_n,
    input  logic             osc_tick,
    input  logic             long_sel,
    input  logic             conv_src,
    output logic             eoc_o,
    output logic             int_n_o,
    output logic             sampling_o,
    output logic             ext_mode_o,
    output logic             early_err_o,
    output logic [OVR_W-1:0] overrun_o,
    output logic [RES_W-1:0] result_o,
    output logic             result_valid_o
);

    localparam int FALL_W = $clog2(LONG_FALLS + 1);
    localparam int RISE_W = $clog2(STRB_MIN_RISES + 1);
    localparam logic [FALL_W-1:0] SHORT_LAST = FALL_W'(SHORT_FALLS - 1);
    localparam logic [FALL_W-1:0] LONG_LAST  = FALL_W'(LONG_FALLS - 1);
    localparam logic [RISE_W-1:0] RISE_MIN   = RISE_W'(STRB_MIN_RISES);
    localparam logic [NUM_EDGE_IN-1:0] EDGE_RST = NUM_EDGE_IN'(4'b1010);

    // ---------------- edge detection ----------------
    logic [NUM_EDGE_IN-1:0] lvl, rise, fall;
    assign lvl = {strobe_n, fs, cs_n, sclk};

    adc_edge_det #(.N(NUM_EDGE_IN), .RST_VAL(EDGE_RST)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .level (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    logic sclk_rise, sclk_fall, frame, st_fall, st_rise, edge_unused;
    assign sclk_rise   = rise[IX_SCLK];
    assign sclk_fall   = fall[IX_SCLK];
    assign frame       = fall[IX_CS] | rise[IX_FS];
    assign st_fall     = fall[IX_STRB];
    assign st_rise     = rise[IX_STRB];
    assign edge_unused = rise[IX_CS] ^ fall[IX_FS];

    // ---------------- state and counters ----------------
    tmr_state_e        state, state_n;
    logic [FALL_W-1:0] fall_cnt, fall_last;
    logic [RISE_W-1:0] rise_cnt;
    logic              ext_mode_q, exit_armed;
    logic              cnt_clr, set_err, ovr_inc;
    logic              ext_set, ext_clr, exit_arm, exit_clr;
    logic              conv_start, conv_run, conv_done;

    assign fall_last  = long_sel ? LONG_LAST : SHORT_LAST;
    assign conv_run   = (state == ST_CONVERT);
    assign conv_start = (state != ST_CONVERT) && (state_n == ST_CONVERT);

    adc_conv_clk #(.CONV_CLKS(CONV_CLKS), .SCLK_DIV(SCLK_DIV)) u_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (conv_start),
        .run       (conv_run),
        .use_sclk  (conv_src),
        .sclk_rise (sclk_rise),
        .osc_tick  (osc_tick),
        .done      (conv_done)
    );

    // next-state and event decode
    always_comb begin
        state_n  = state;
        cnt_clr  = 1'b0;
        set_err  = 1'b0;
        ovr_inc  = 1'b0;
        ext_set  = 1'b0;
        ext_clr  = 1'b0;
        exit_arm = 1'b0;
        exit_clr = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (frame) begin
                    if (ext_mode_q && !exit_armed) begin
                        exit_arm = 1'b1;
                    end else begin
                        ext_clr = 1'b1;
                        exit_clr = 1'b1;
                        cnt_clr = 1'b1;
                        state_n = ST_SAMPLE;
                    end
                end else if (st_fall) begin
                    if (ext_mode_q) begin
                        exit_clr = 1'b1;
                        state_n  = ST_EXT_SAMPLE;
                    end else begin
                        set_err = 1'b1;
                    end
                end
            end
            ST_SAMPLE: begin
                if (st_fall) begin
                    if (rise_cnt >= RISE_MIN) begin
                        ext_set = 1'b1;
                        state_n = ST_EXT_SAMPLE;
                    end else begin
                        set_err = 1'b1;
                    end
                end else if (sclk_fall && fall_cnt == fall_last) begin
                    state_n = ST_CONVERT;
                end
            end
            ST_EXT_SAMPLE: begin
                if (st_rise) state_n = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (frame || st_fall) ovr_inc = 1'b1;
                if (conv_done) state_n = ST_IDLE;
            end
        endcase
    end

    // state register and frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            fall_cnt   <= '0;
            rise_cnt   <= '0;
            ext_mode_q <= 1'b0;
            exit_armed <= 1'b0;
        end else begin
            state <= state_n;
            if (cnt_clr) begin
                fall_cnt <= '0;
                rise_cnt <= '0;
            end else if (state == ST_SAMPLE) begin
                if (sclk_fall) fall_cnt <= fall_cnt + 1'b1;
                if (sclk_rise && rise_cnt < RISE_MIN) rise_cnt <= rise_cnt + 1'b1;
            end
            if (ext_set)      ext_mode_q <= 1'b1;
            else if (ext_clr) ext_mode_q <= 1'b0;
            if (exit_arm)      exit_armed <= 1'b1;
            else if (exit_clr) exit_armed <= 1'b0;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoc_o          <= 1'b1;
            int_n_o        <= 1'b1;
            sampling_o     <= 1'b0;
            early_err_o    <= 1'b0;
            overrun_o      <= '0;
            result_o       <= '0;
            result_valid_o <= 1'b0;
        end else begin
            eoc_o          <= (state_n != ST_CONVERT);
            sampling_o     <= (state_n == ST_SAMPLE) || (state_n == ST_EXT_SAMPLE);
            result_valid_o <= conv_done;
            if (conv_done)  result_o <= RESULT_STUB;
            if (conv_done)  int_n_o <= 1'b0;
            else if (frame) int_n_o <= 1'b1;
            if (set_err)    early_err_o <= 1'b1;
            if (ovr_inc && overrun_o != '1) overrun_o <= overrun_o + 1'b1;
        end
    end

    assign ext_mode_o = ext_mode_q;

    // R3: sampling never runs past the selected falling-edge count
    a_r3_fall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAMPLE) |-> (fall_cnt <= fall_last));

    // R9: end of conversion raises the interrupt and presents the result
    a_r9_eoc_int: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_o) |-> (!int_n_o && result_valid_o));

    // R6: the early-strobe flag is sticky
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(early_err_o) |-> early_err_o);

    // R11: a trigger during conversion does not end it
    a_r11_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_run && (frame || st_fall) && !conv_done) |=> !eoc_o);

    // R10: a frame edge releases the interrupt
    a_r10_int_release: assert property (@(posedge clk) disable iff (!rst_n)
        (frame && !conv_done) |=> int_n_o);

    // R5: extended sampling only ends in conversion
    a_r5_ext_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXT_SAMPLE) |=> (state == ST_EXT_SAMPLE || state == ST_CONVERT));

endmodule

// File: tb/test_adc_sample_timer.sv
module test_adc_sample_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, cs_n = 1'b1, fs = 1'b0, strobe_n = 1'b1;
    logic       osc_tick = 1'b0, long_sel = 1'b0, conv_src = 1'b0;
    logic       eoc_o, int_n_o, sampling_o, ext_mode_o, early_err_o, result_valid_o;
    logic [3:0] overrun_o;
    logic [11:0] result_o;

    int n_chk = 0, n_fail = 0, cyc = 0, osc_per = 1, run_len = 0, last_low = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_sample_timer i_adc_sample_timer (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .fs(fs),
        .strobe_n(strobe_n), .osc_tick(osc_tick), .long_sel(long_sel),
        .conv_src(conv_src), .eoc_o(eoc_o), .int_n_o(int_n_o),
        .sampling_o(sampling_o), .ext_mode_o(ext_mode_o),
        .early_err_o(early_err_o), .overrun_o(overrun_o), .result_o(result_o),
        .result_valid_o(result_valid_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_ph, m_rise, m_fall, m_cc, m_div, m_ovr, m_res;
    bit m_ext, m_arm, m_err, m_int, m_eoc, m_smp, m_rv;
    bit p_sclk, p_cs, p_fs, p_st;

    always @(posedge clk) begin : model
        bit sr, sf, frm, tf, tr, tick, done;
        int nxt;
        if (!rst_n) begin
            m_ph = 0; m_rise = 0; m_fall = 0; m_cc = 0; m_div = 0; m_ovr = 0; m_res = 0;
            m_ext = 0; m_arm = 0; m_err = 0; m_int = 1; m_eoc = 1; m_smp = 0; m_rv = 0;
            p_sclk = 0; p_cs = 1; p_fs = 0; p_st = 1;
        end else begin
            sr   = sclk && !p_sclk;
            sf   = !sclk && p_sclk;
            frm  = (!cs_n && p_cs) || (fs && !p_fs);
            tf   = !strobe_n && p_st;
            tr   = strobe_n && !p_st;
            tick = conv_src ? (sr && m_div == 3) : osc_tick;
            done = (m_ph == 3) && tick && (m_cc == 12);
            nxt  = m_ph;
            m_rv = 0;
            if (m_ph == 0) begin
                if (frm) begin
                    if (m_ext && !m_arm) m_arm = 1;
                    else begin m_ext = 0; m_arm = 0; m_rise = 0; m_fall = 0; nxt = 1; end
                end else if (tf) begin
                    if (m_ext) begin nxt = 2; m_arm = 0; end
                    else m_err = 1;
                end
            end else if (m_ph == 1) begin
                if (tf) begin
                    if (m_rise >= 11) begin nxt = 2; m_ext = 1; end
                    else m_err = 1;
                end else if (sf && m_fall + 1 == (long_sel ? 48 : 16)) nxt = 3;
                if (sr) m_rise++;
                if (sf) m_fall++;
            end else if (m_ph == 2) begin
                if (tr) nxt = 3;
            end else begin
                if ((frm || tf) && m_ovr < 15) m_ovr++;
                if (sr) m_div = (m_div + 1) % 4;
                if (tick) m_cc++;
                if (done) begin nxt = 0; m_res = 'hA5C; m_rv = 1; end
            end
            if (nxt == 3 && m_ph != 3) begin m_cc = 0; m_div = 0; end
            if (done) m_int = 0;
            else if (frm) m_int = 1;
            m_ph  = nxt;
            m_eoc = (nxt != 3);
            m_smp = (nxt == 1 || nxt == 2);
            p_sclk = sclk; p_cs = cs_n; p_fs = fs; p_st = strobe_n;
        end
    end

    // compare every clock, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        chk("R9 eoc",          eoc_o,          m_eoc);
        chk("R10 int_n",       int_n_o,        m_int);
        chk("R2 sampling",     sampling_o,     m_smp);
        chk("R5 ext_mode",     ext_mode_o,     m_ext);
        chk("R6 early_err",    early_err_o,    m_err);
        chk("R11 overrun",     overrun_o,      m_ovr);
        chk("R9 result",       result_o,       m_res);
        chk("R9 result_valid", result_valid_o, m_rv);
        if (!eoc_o) run_len++;
        else if (run_len != 0) begin last_low = run_len; run_len = 0; end
    end

    // oscillator tick source
    always @(negedge clk) begin
        cyc++;
        osc_tick = (osc_per != 0) && (cyc % osc_per == 0);
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sclk = 1'b1;
            @(negedge clk) sclk = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        // R1: reset values
        wait_clk(4);
        chk("R1 eoc", eoc_o, 1);            chk("R1 int_n", int_n_o, 1);
        chk("R1 sampling", sampling_o, 0);  chk("R1 overrun", overrun_o, 0);
        chk("R1 result", result_o, 0);      chk("R1 err", early_err_o, 0);
        rst_n = 1'b1;
        wait_clk(3);

        // R3: short frame, oscillator ticks every clock
        osc_per = 1; long_sel = 0; conv_src = 0;
        cs_n = 1'b0;
        wait_clk(2);
        chk("R2 frame start", sampling_o, 1);
        pulses(15);
        chk("R3 15th fall", eoc_o, 1);
        pulses(1);
        chk("R3 16th fall", eoc_o, 0);
        wait_clk(20);
        chk("R8 osc length", last_low, 13);
        chk("R9 int low", int_n_o, 0);
        cs_n = 1'b1;
        wait_clk(3);

        // R4: long frame through frame sync, serial-clock conversion clocks
        long_sel = 1; conv_src = 1;
        fs = 1'b1;
        @(negedge clk) fs = 1'b0;
        wait_clk(1);
        chk("R10 int release", int_n_o, 1);
        pulses(47);
        chk("R4 47th fall", eoc_o, 1);
        pulses(1);
        chk("R4 48th fall", eoc_o, 0);
        pulses(51);
        chk("R8 sclk 51 rises", eoc_o, 0);
        pulses(1);
        chk("R8 sclk 52 rises", eoc_o, 1);
        long_sel = 0; conv_src = 0;
        wait_clk(3);

        // R6: strobe after only 10 rising edges is rejected
        cs_n = 1'b0;
        wait_clk(2);
        pulses(10);
        strobe_n = 1'b0;
        wait_clk(3);
        chk("R6 early err", early_err_o, 1);
        chk("R6 not extended", ext_mode_o, 0);
        strobe_n = 1'b1;
        wait_clk(2);
        pulses(6);
        chk("R6 normal conversion", eoc_o, 0);
        wait_clk(20);
        cs_n = 1'b1;
        wait_clk(3);

        // R5: strobe after exactly 11 rising edges enters extended mode
        osc_per = 1;
        cs_n = 1'b0;
        wait_clk(2);
        pulses(11);
        strobe_n = 1'b0;
        wait_clk(8);
        chk("R5 ext entry", ext_mode_o, 1);
        chk("R5 ext sampling", sampling_o, 1);
        strobe_n = 1'b1;
        wait_clk(2);
        chk("R5 rise converts", eoc_o, 0);
        wait_clk(20);
        cs_n = 1'b1;
        wait_clk(3);
        // later strobe in idle, with a chip-select edge during conversion
        strobe_n = 1'b0;
        wait_clk(5);
        strobe_n = 1'b1;
        wait_clk(3);
        cs_n = 1'b0;
        wait_clk(2);
        chk("R11 one overrun", overrun_o, 1);
        chk("R11 still converting", eoc_o, 0);
        cs_n = 1'b1;
        wait_clk(20);

        // R7: leave extended mode with two chip-select edges
        cs_n = 1'b0;
        wait_clk(2);
        chk("R7 first edge no sample", sampling_o, 0);
        chk("R7 still extended", ext_mode_o, 1);
        cs_n = 1'b1;
        wait_clk(2);
        cs_n = 1'b0;
        wait_clk(2);
        chk("R7 second edge samples", sampling_o, 1);
        chk("R7 ext cleared", ext_mode_o, 0);
        pulses(16);
        wait_clk(20);

        // R11: saturation during a slow conversion
        cs_n = 1'b1;
        osc_per = 50;
        wait_clk(3);
        cs_n = 1'b0;
        wait_clk(2);
        pulses(16);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk) cs_n = 1'b1;
            wait_clk(1);
            @(negedge clk) cs_n = 1'b0;
            wait_clk(1);
        end
        chk("R11 saturated", overrun_o, 15);
        chk("R11 conversion kept", eoc_o, 0);
        wait_clk(700);
        chk("R9 late result", result_o, 'hA5C);
        cs_n = 1'b1;
        wait_clk(5);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule